// File: doc/BRIEF.md
# Asynchronous Serial Port with Bit-Rate Clock Output

This block is a full-duplex asynchronous serial transmitter and receiver with a register-style control interface. Software-visible state is a one-byte transmit holding register with an empty flag, and a one-byte receive register with a full flag and three error flags: parity, framing and overrun. Separate level enables gate the transmitter and the receiver. The frame format is set by three controls: parity on or off, even or odd parity, and one or two stop bits.

Both directions time their bits from a common 16x sub-bit tick. The tick comes from a programmable divider of the system clock or from an external clock on the serial clock pin that runs at sixteen times the bit rate. When the internal divider is the source, the block can drive a bit-rate clock onto the serial clock pin. That clock is low for the first half of each transmitted bit and high for the second half, so each rising edge falls at the centre of the bit. Disabling the transmitter aborts any frame at once. Disabling the receiver only stops reception and keeps every receive flag and the received byte.

Top module: `async_serial_port`

## Requirements
- R1: A transmitted frame is a low start bit, then 8 data bits least-significant first, then an optional parity bit, then 1 stop bit (`twoStop`=0) or 2 stop bits (`twoStop`=1), all stop bits high. `txd` is high when no frame is in progress.
- R2: With `parityEn`=1 a parity bit follows the data. With `parityOdd`=0 the count of ones over the data and parity bits is even; with `parityOdd`=1 it is odd.
- R3: One bit lasts 16 sub-bit ticks. Under the internal source one tick occurs every `baudDiv`+1 system clocks. Under the external source each rising edge of `sckIn` is one tick.
- R4: `clkSel` encoding: 00 selects the internal source with `sckOe`=0; 01 selects the internal source and drives the bit clock (`sckOe`=1); 1x selects the external source on `sckIn` with `sckOe`=0.
- R5: While `sckOe`=1, `sckOut` is low for the first 8 ticks of each transmitted bit and high for the last 8, so it rises at the bit centre and falls at each bit boundary.
- R6: A `txWrite` while `txEnable`=1 clears `txEmpty` on the next clock. The byte moves to the shift register at the next bit boundary when the line is idle, or at the end of the last stop bit so that frames follow back to back. `txEmpty` is set again in that same cycle.
- R7: With `txEnable`=0 the transmitter is held reset: `txEmpty`=1, `txd`=1, a frame in progress is dropped, and `txWrite` has no effect.
- R8: The receiver samples each bit at its eighth tick. A start bit that is high at its mid-point is rejected. On the first stop bit sample, an accepted byte appears on `rxData` and sets `rxFull`. `rxRead` clears `rxFull`.
- R9: `parityErr` is set when a received parity bit does not match the `parityOdd` setting (encoding as in R2).
- R10: `frameErr` is set when the first stop bit samples low. The byte is still delivered.
- R11: A frame that completes while `rxFull`=1 sets `overrunErr`, and the new byte is discarded: `rxData` keeps the old byte.
- R12: With `rxEnable`=0, `rxData`, `rxFull` and the three error flags keep their values and line activity is ignored. `errClear` clears the three error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Transmitter enable; low holds it reset |
| rxEnable | input | 1 | Receiver enable |
| parityEn | input | 1 | Add and check a parity bit |
| parityOdd | input | 1 | 1 odd parity, 0 even parity |
| twoStop | input | 1 | Transmit two stop bits |
| clkSel | input | 2 | Tick source and clock output select |
| baudDiv | input | DIV_W | Internal divider: tick every baudDiv+1 clocks |
| txWrite | input | 1 | Write strobe for the transmit holding register |
| txData | input | 8 | Byte to transmit |
| rxRead | input | 1 | Read acknowledge, clears rxFull |
| errClear | input | 1 | Clears the three error flags |
| rxd | input | 1 | Serial receive line |
| sckIn | input | 1 | External 16x clock |
| txd | output | 1 | Serial transmit line |
| sckOut | output | 1 | Bit-rate clock output |
| sckOe | output | 1 | Output enable for sckOut |
| txEmpty | output | 1 | Transmit holding register empty |
| rxData | output | 8 | Last received byte |
| rxFull | output | 1 | Received byte waiting |
| parityErr | output | 1 | Parity error flag |
| frameErr | output | 1 | Framing error flag |
| overrunErr | output | 1 | Overrun error flag |

## Verification
The bench writes a second byte during a frame and checks that it starts exactly at the end of the first frame's stop bit. A design that reloaded late would leave an extra idle bit between the frames; one that reloaded early would cut the stop bit short. It samples `sckOut` two clocks on each side of every bit centre, which catches a clock that is inverted or off by a sub-bit. It drops the transmitter enable in the middle of a frame and then writes a byte while the transmitter is disabled, which exposes a shift register that keeps running or an empty flag that stays clear. On the receive side it sends a short glitch that must be rejected, a wrong parity bit, a low stop bit and a frame while `rxFull` is still set. It then disables the receiver and sends a frame that must change nothing. A receiver that cleared its flags on disable, or overwrote the old byte on overrun, shows up here.

// File: rtl/asp_pkg.sv
package asp_pkg;
  localparam int DATA_W = 8;
  localparam int SUBS   = 16;

  typedef struct packed {
    logic txLoad;   // move holding byte into shift register
    logic txShift;  // advance one bit
    logic txKill;   // transmitter disabled
    logic rxData;   // sample a data bit
    logic rxPar;    // sample the parity bit
    logic rxStop;   // sample the first stop bit, finish frame
  } strobe_t;
endpackage

// File: rtl/asp_ctrl.sv
module asp_ctrl
  import asp_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEnable,
  input  logic             rxEnable,
  input  logic             parityEn,
  input  logic             twoStop,
  input  logic [1:0]       clkSel,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             sckIn,
  input  logic             rxBit,
  input  logic             holdFull,
  output strobe_t          stb,
  output logic             sckOut,
  output logic             sckOe
);
  localparam int SUB_W = $clog2(SUBS);
  localparam int BIT_W = 4;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUBS - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(SUBS / 2 - 1);
  localparam logic [BIT_W-1:0] IDX_LAST_DATA = BIT_W'(DATA_W);
  localparam logic [BIT_W-1:0] IDX_PAR       = BIT_W'(DATA_W + 1);

  // tick source
  logic [DIV_W-1:0] divCnt;
  logic [2:0]       sckSync;
  logic             intTick, extTick, tick;

  assign intTick = !clkSel[1] && (divCnt >= baudDiv);
  assign extTick = clkSel[1] && sckSync[1] && !sckSync[2];
  assign tick    = intTick || extTick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt  <= '0;
      sckSync <= '0;
    end else begin
      sckSync <= {sckSync[1:0], sckIn};
      if (clkSel[1] || divCnt >= baudDiv) divCnt <= '0;
      else divCnt <= divCnt + 1'b1;
    end
  end

  // transmit sequencing
  logic [SUB_W-1:0] txSub;
  logic [BIT_W-1:0] txLeft, frameLen;
  logic             bitEnd;

  assign bitEnd   = tick && (txSub == SUB_LAST);
  assign frameLen = BIT_W'(DATA_W + 2) + {{(BIT_W-1){1'b0}}, parityEn}
                  + {{(BIT_W-1){1'b0}}, twoStop};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSub  <= '0;
      txLeft <= '0;
    end else begin
      if (tick) txSub <= txSub + 1'b1;
      if (!txEnable) txLeft <= '0;
      else if (bitEnd) begin
        if (txLeft <= BIT_W'(1) && holdFull) txLeft <= frameLen;
        else if (txLeft != '0) txLeft <= txLeft - 1'b1;
      end
    end
  end

  assign sckOe  = (clkSel == 2'b01);
  assign sckOut = sckOe && txSub[SUB_W-1];

  // receive sequencing
  logic             rxActive, rxMid;
  logic [SUB_W-1:0] rxSub;
  logic [BIT_W-1:0] rxIdx, stopIdx;

  assign stopIdx = parityEn ? BIT_W'(DATA_W + 2) : BIT_W'(DATA_W + 1);
  assign rxMid   = rxEnable && rxActive && tick && (rxSub == SUB_MID);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxActive <= 1'b0;
      rxSub    <= '0;
      rxIdx    <= '0;
    end else if (!rxEnable) begin
      rxActive <= 1'b0;
    end else if (!rxActive) begin
      if (tick && !rxBit) begin
        rxActive <= 1'b1;
        rxSub    <= '0;
        rxIdx    <= '0;
      end
    end else if (tick) begin
      rxSub <= rxSub + 1'b1;
      if (rxSub == SUB_MID) begin
        if ((rxIdx == '0 && rxBit) || rxIdx == stopIdx) rxActive <= 1'b0;
        else rxIdx <= rxIdx + 1'b1;
      end
    end
  end

  always_comb begin
    stb         = '0;
    stb.txKill  = !txEnable;
    stb.txLoad  = txEnable && bitEnd && (txLeft <= BIT_W'(1)) && holdFull;
    stb.txShift = txEnable && bitEnd && (txLeft != '0) && !stb.txLoad;
    stb.rxData  = rxMid && (rxIdx >= BIT_W'(1)) && (rxIdx <= IDX_LAST_DATA);
    stb.rxPar   = rxMid && parityEn && (rxIdx == IDX_PAR);
    stb.rxStop  = rxMid && (rxIdx == stopIdx);
  end

  // R6: at most one transmit action per cycle
  p_tx_one_action_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.txLoad, stb.txShift, stb.txKill}));

  // R5: a new frame starts on a bit boundary, where the output clock is high before it falls
  p_load_on_boundary_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.txLoad && sckOe) |-> sckOut);

  // R5: the output clock only changes on ticks
  p_sck_moves_on_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && $stable(clkSel)) |=> $stable(sckOut));
endmodule

// File: rtl/asp_datapath.sv
module asp_datapath
  import asp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              rxRead,
  input  logic              errClear,
  input  logic              rxd,
  output logic              rxBit,
  output logic              holdFull,
  output logic              txd,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              parityErr,
  output logic              frameErr,
  output logic              overrunErr
);
  localparam int FRAME_W = DATA_W + 4;

  logic [DATA_W-1:0]  holdReg, rxShift;
  logic [FRAME_W-1:0] txSr, txFrame;
  logic [1:0]         rxSync;
  logic               txPar, rxParBit, rxParBad;

  assign txPar   = ^holdReg ^ parityOdd;
  assign txFrame = parityEn ? {2'b11, txPar, holdReg, 1'b0}
                            : {3'b111, holdReg, 1'b0};
  assign txd     = txSr[0];
  assign rxBit   = rxSync[1];
  assign rxParBad = parityEn && (rxParBit != (^rxShift ^ parityOdd));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
      txSr     <= '1;
    end else if (stb.txKill) begin
      holdFull <= 1'b0;
      txSr     <= '1;
    end else begin
      if (stb.txLoad) begin
        txSr     <= txFrame;
        holdFull <= 1'b0;
      end else if (stb.txShift) begin
        txSr <= {1'b1, txSr[FRAME_W-1:1]};
      end
      if (txWrite) begin
        holdReg  <= txData;
        holdFull <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSync     <= 2'b11;
      rxShift    <= '0;
      rxParBit   <= 1'b0;
      rxData     <= '0;
      rxFull     <= 1'b0;
      parityErr  <= 1'b0;
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      rxSync <= {rxSync[0], rxd};
      if (stb.rxData) rxShift <= {rxBit, rxShift[DATA_W-1:1]};
      if (stb.rxPar) rxParBit <= rxBit;
      if (rxRead) rxFull <= 1'b0;
      if (errClear) begin
        parityErr  <= 1'b0;
        frameErr   <= 1'b0;
        overrunErr <= 1'b0;
      end
      if (stb.rxStop) begin
        if (rxFull) overrunErr <= 1'b1;
        else begin
          rxData <= rxShift;
          rxFull <= 1'b1;
          if (rxParBad) parityErr <= 1'b1;
          if (!rxBit) frameErr <= 1'b1;
        end
      end
    end
  end

  // R7: a disabled transmitter is empty and idles high
  p_kill_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.txKill |=> (!holdFull && txd));

  // R11: an overrun keeps the old byte
  p_overrun_keeps_byte_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rxStop && rxFull) |=> (overrunErr && $stable(rxData)));

  // R8: the full flag only rises at a stop-bit sample
  p_full_on_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> $past(stb.rxStop));
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port
  import asp_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEnable,
  input  logic             rxEnable,
  input  logic             parityEn,
  input  logic             parityOdd,
  input  logic             twoStop,
  input  logic [1:0]       clkSel,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             txWrite,
  input  logic [7:0]       txData,
  input  logic             rxRead,
  input  logic             errClear,
  input  logic             rxd,
  input  logic             sckIn,
  output logic             txd,
  output logic             sckOut,
  output logic             sckOe,
  output logic             txEmpty,
  output logic [7:0]       rxData,
  output logic             rxFull,
  output logic             parityErr,
  output logic             frameErr,
  output logic             overrunErr
);
  strobe_t stb;
  logic    rxBit, holdFull;

  asp_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .rxEnable(rxEnable),
    .parityEn(parityEn), .twoStop(twoStop), .clkSel(clkSel), .baudDiv(baudDiv),
    .sckIn(sckIn), .rxBit(rxBit), .holdFull(holdFull), .stb(stb),
    .sckOut(sckOut), .sckOe(sckOe)
  );

  asp_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txWrite(txWrite), .txData(txData),
    .parityEn(parityEn), .parityOdd(parityOdd), .rxRead(rxRead),
    .errClear(errClear), .rxd(rxd), .rxBit(rxBit), .holdFull(holdFull),
    .txd(txd), .rxData(rxData), .rxFull(rxFull), .parityErr(parityErr),
    .frameErr(frameErr), .overrunErr(overrunErr)
  );

  assign txEmpty = !holdFull;

  // R12: a disabled receiver keeps its byte and flags
  p_rx_disabled_holds_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && !rxRead && !errClear) |=>
      $stable({rxData, rxFull, parityErr, frameErr, overrunErr}));
endmodule

// File: tb/async_serial_port_tb.sv
module async_serial_port_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txEnable = 1'b0, rxEnable = 1'b0;
  logic       parityEn = 1'b0, parityOdd = 1'b0, twoStop = 1'b0;
  logic [1:0] clkSel = 2'b00;
  logic [7:0] baudDiv = 8'd3;
  logic       txWrite = 1'b0;
  logic [7:0] txData = 8'h00;
  logic       rxRead = 1'b0, errClear = 1'b0;
  logic       rxd = 1'b1, sckIn = 1'b0, extRun = 1'b0;
  logic       txd, sckOut, sckOe, txEmpty, rxFull, parityErr, frameErr, overrunErr;
  logic [7:0] rxData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  // external 16x clock: one rising edge every 8 system clocks
  always begin
    repeat (4) @(posedge clk);
    if (extRun) sckIn <= ~sckIn;
  end

  async_serial_port #(.DIV_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .rxEnable(rxEnable),
    .parityEn(parityEn), .parityOdd(parityOdd), .twoStop(twoStop),
    .clkSel(clkSel), .baudDiv(baudDiv), .txWrite(txWrite), .txData(txData),
    .rxRead(rxRead), .errClear(errClear), .rxd(rxd), .sckIn(sckIn),
    .txd(txd), .sckOut(sckOut), .sckOe(sckOe), .txEmpty(txEmpty),
    .rxData(rxData), .rxFull(rxFull), .parityErr(parityErr),
    .frameErr(frameErr), .overrunErr(overrunErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeTx(input logic [7:0] d);
    txData = d; txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
  endtask

  // frame expectation built from R1/R2
  function automatic logic [11:0] expFrame(input logic [7:0] d, input bit par, input bit odd);
    return par ? {2'b11, (^d) ^ odd, d, 1'b0} : {3'b111, d, 1'b0};
  endfunction

  // waits for a start bit, then checks every bit at its centre (and the clock around it)
  task automatic captureTx(input logic [7:0] d, input bit par, input bit odd, input bit two,
                           input int bitClk, input bit sck, input int timeoutClk,
                           input bit doNext, input logic [7:0] nextD,
                           input string req, output int waited);
    logic [11:0] f = expFrame(d, par, odd);
    int len = 10 + int'(par) + int'(two);
    int n = 0;
    while (txd !== 1'b0 && n < timeoutClk) begin
      @(negedge clk);
      n++;
    end
    waited = n;
    check(txd === 1'b0, {req, " start bit seen"}, int'(txd), 0);
    for (int k = 0; k < len; k++) begin
      if (k == 0) begin
        if (doNext) begin
          writeTx(nextD);
          check(txEmpty == 1'b0, "R6 write clears empty during frame", int'(txEmpty), 0);
          waitClk(bitClk / 2 - 3);
        end else waitClk(bitClk / 2 - 2);
      end else waitClk(bitClk - 2);
      if (sck) check(sckOut == 1'b0, "R5 clock low before centre", int'(sckOut), 0);
      waitClk(2);
      check(txd == f[k], {req, " bit value"}, int'(txd), int'(f[k]));
      if (sck) check(sckOut == 1'b1, "R5 clock high after centre", int'(sckOut), 1);
    end
  endtask

  task automatic sendRx(input logic [7:0] d, input bit odd, input bit withPar,
                        input bit badPar, input bit badStop, input int bitClk);
    rxd = 1'b0; waitClk(bitClk);
    for (int k = 0; k < 8; k++) begin
      rxd = d[k]; waitClk(bitClk);
    end
    if (withPar) begin
      rxd = (^d) ^ odd ^ badPar; waitClk(bitClk);
    end
    if (badStop) begin
      rxd = 1'b0; waitClk(bitClk * 11 / 16);
      rxd = 1'b1; waitClk(bitClk - bitClk * 11 / 16);
    end else begin
      rxd = 1'b1; waitClk(bitClk);
    end
    waitClk(bitClk);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    report();
  end

  initial begin
    int w;
    waitClk(5);
    rstN = 1'b1;
    waitClk(2);
    // reset state
    check(txd == 1'b1, "R1 idle line high after reset", int'(txd), 1);
    check(txEmpty == 1'b1, "R6 empty after reset", int'(txEmpty), 1);
    check(rxFull == 1'b0, "R8 not full after reset", int'(rxFull), 0);
    check({parityErr, frameErr, overrunErr} == 3'b000, "R9 flags clear after reset",
          int'({parityErr, frameErr, overrunErr}), 0);
    check(sckOe == 1'b0, "R4 clkSel 00 leaves clock undriven", int'(sckOe), 0);

    // internal clock with output, 8N1
    clkSel = 2'b01; txEnable = 1'b1; rxEnable = 1'b1;
    waitClk(1);
    check(sckOe == 1'b1, "R4 clkSel 01 drives clock", int'(sckOe), 1);
    writeTx(8'hA5);
    check(txEmpty == 1'b0, "R6 write clears empty", int'(txEmpty), 0);
    captureTx(8'hA5, 0, 0, 0, 64, 1, 200, 0, 8'h00, "R1 R3 frame A5", w);
    check(txEmpty == 1'b1, "R6 empty after load", int'(txEmpty), 1);

    // back to back frames
    waitClk(64);
    writeTx(8'h3C);
    captureTx(8'h3C, 0, 0, 0, 64, 1, 200, 1, 8'hC3, "R1 frame 3C", w);
    captureTx(8'hC3, 0, 0, 0, 64, 1, 64, 0, 8'h00, "R6 back-to-back C3", w);
    check(w <= 34, "R6 next frame follows stop bit", w, 33);

    // parity, two stop bits
    parityEn = 1'b1; twoStop = 1'b1; parityOdd = 1'b0;
    waitClk(128);
    writeTx(8'h07);
    captureTx(8'h07, 1, 0, 1, 64, 1, 200, 0, 8'h00, "R2 even parity 07", w);
    parityOdd = 1'b1;
    waitClk(128);
    writeTx(8'h07);
    captureTx(8'h07, 1, 1, 1, 64, 1, 200, 0, 8'h00, "R2 odd parity 07", w);
    parityEn = 1'b0; twoStop = 1'b0; parityOdd = 1'b0;
    waitClk(128);

    // disable mid frame
    writeTx(8'h81);
    w = 0;
    while (txd !== 1'b0 && w < 200) begin @(negedge clk); w++; end
    waitClk(200);
    txEnable = 1'b0;
    waitClk(1);
    check(txd == 1'b1, "R7 disable drops frame", int'(txd), 1);
    check(txEmpty == 1'b1, "R7 disable sets empty", int'(txEmpty), 1);
    writeTx(8'h55);
    check(txEmpty == 1'b1, "R7 write ignored while disabled", int'(txEmpty), 1);
    txEnable = 1'b1;
    w = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (txd !== 1'b1) w++;
    end
    check(w == 0, "R7 no frame after re-enable", w, 0);

    // external 16x clock
    clkSel = 2'b10; extRun = 1'b1;
    waitClk(40);
    check(sckOe == 1'b0, "R4 clkSel 1x leaves clock undriven", int'(sckOe), 0);
    writeTx(8'h6E);
    captureTx(8'h6E, 0, 0, 0, 128, 0, 400, 0, 8'h00, "R3 external clock frame 6E", w);
    waitClk(128);
    extRun = 1'b0; clkSel = 2'b00;
    waitClk(64);

    // receive: clean frame
    sendRx(8'h5A, 0, 0, 0, 0, 64);
    check(rxFull == 1'b1, "R8 frame sets full", int'(rxFull), 1);
    check(rxData == 8'h5A, "R8 received byte", int'(rxData), 'h5A);
    check({parityErr, frameErr, overrunErr} == 3'b000, "R8 no errors on clean frame",
          int'({parityErr, frameErr, overrunErr}), 0);
    pulse(rxRead);
    check(rxFull == 1'b0, "R8 read clears full", int'(rxFull), 0);

    // glitch on the line
    rxd = 1'b0; waitClk(8); rxd = 1'b1;
    waitClk(64 * 12);
    check(rxFull == 1'b0, "R8 short low pulse rejected", int'(rxFull), 0);

    // parity error then good odd parity
    parityEn = 1'b1; parityOdd = 1'b0;
    sendRx(8'h01, 0, 1, 1, 0, 64);
    check(parityErr == 1'b1, "R9 wrong parity flagged", int'(parityErr), 1);
    check(rxData == 8'h01, "R9 byte delivered with parity error", int'(rxData), 1);
    pulse(rxRead);
    pulse(errClear);
    check(parityErr == 1'b0, "R12 errClear clears parity flag", int'(parityErr), 0);
    parityOdd = 1'b1;
    sendRx(8'hF0, 1, 1, 0, 0, 64);
    check(parityErr == 1'b0, "R9 correct odd parity accepted", int'(parityErr), 0);
    check(rxData == 8'hF0, "R9 byte F0 received", int'(rxData), 'hF0);
    pulse(rxRead);
    parityEn = 1'b0; parityOdd = 1'b0;

    // framing error
    sendRx(8'h33, 0, 0, 0, 1, 64);
    check(frameErr == 1'b1, "R10 low stop flagged", int'(frameErr), 1);
    check(rxData == 8'h33, "R10 byte delivered", int'(rxData), 'h33);
    pulse(rxRead);
    pulse(errClear);

    // overrun
    sendRx(8'h11, 0, 0, 0, 0, 64);
    sendRx(8'h99, 0, 0, 0, 0, 64);
    check(overrunErr == 1'b1, "R11 overrun flagged", int'(overrunErr), 1);
    check(rxData == 8'h11, "R11 old byte kept", int'(rxData), 'h11);
    check(rxFull == 1'b1, "R11 still full", int'(rxFull), 1);

    // receiver disable keeps state
    rxEnable = 1'b0;
    sendRx(8'h77, 0, 0, 0, 0, 64);
    check(rxData == 8'h11, "R12 data kept while disabled", int'(rxData), 'h11);
    check(rxFull == 1'b1 && overrunErr == 1'b1, "R12 flags kept while disabled",
          int'({rxFull, overrunErr}), 3);
    pulse(errClear);
    check(overrunErr == 1'b0, "R12 errClear clears overrun", int'(overrunErr), 0);
    check(rxFull == 1'b1, "R12 errClear leaves full", int'(rxFull), 1);

    report();
  end
endmodule